// File: doc/BRIEF.md
# EDID memory I2C target

This block is a bus target that serves a 256-byte display-identification RAM over a two-wire, DDC-style serial bus. It receives SCL and SDA as clean logic levels that have already been filtered and synchronised to its clock. From these levels it detects start, repeated start and stop conditions. It compares the address byte with a 7-bit target address that configuration can change. When the address matches, it acknowledges and either accepts a byte offset followed by write data, or returns read data from the current offset.

An internal byte pointer steps by one after every data byte in either direction and wraps from 255 to 0. This supports both the usual "set offset, repeated start, sequential read" access and a current-address read that continues where the last transfer stopped. A write-lock input makes the RAM read-only. In that mode, data bytes are still acknowledged but are thrown away.

The SDA pull-down is changed only a programmable number of clock cycles after each SCL falling edge. The block is meant to run at 25 MHz, where one cycle is 40 ns. At that rate the four codes give 240, 280, 320 and 360 ns.

Top module: `edid_i2c_target`

## Requirements
- R1: A start condition (SDA falling while SCL is high) starts an address phase from any state, and this includes a repeated start in the middle of a transfer. A stop condition (SDA rising while SCL is high) returns the block to idle.
- R2: Address byte bits 7:1 are compared with `cfg_dev_addr`, and bit 0 selects the direction (1 = read). On a match the target pulls SDA low in the ninth clock. On a mismatch it never pulls SDA low in that transfer and stores nothing.
- R3: In a write transfer, the first byte after the address is taken as the byte offset and is acknowledged.
- R4: Each later write byte is acknowledged and stored at the pointer. The pointer then steps by one, and it wraps from 255 to 0.
- R5: While `cfg_wr_lock` is 1, write data bytes are still acknowledged but the RAM keeps its earlier contents.
- R6: In a read transfer, the target sends the byte at the pointer MSB first and steps the pointer after each byte, with wrap. A read that has no offset phase continues from the pointer that the previous transfer left.
- R7: When the master does not acknowledge a read byte, the target releases SDA and drives nothing more until the next start.
- R8: Every change of `sda_pull` occurs exactly 6 + `cfg_dly_code` clock edges after the edge that first samples SCL low.
- R9: After reset, SDA is released and the block is idle. Bits clocked on the bus without a start are ignored and are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (25 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Filtered, synchronised SCL level |
| sda_i | input | 1 | Filtered, synchronised SDA bus level |
| cfg_dev_addr | input | 7 | Target address that is compared with address byte bits 7:1 |
| cfg_wr_lock | input | 1 | 1 = RAM is read-only and write data is discarded |
| cfg_dly_code | input | 2 | SDA output delay code; the delay is 6 + code cycles |
| sda_pull | output | 1 | 1 = pull the SDA pad low |

## Verification
Directed transfers cover several cases: a write that runs across the 255-to-0 boundary, and a read back of the same span after a repeated start. They also cover a current-address read that must pick up at the pointer left by the previous transfer, a transfer to a foreign address, bus clocking with no start, and writes made while the lock is set. Together these separate an offset pointer from a data pointer and separate discarded data from stored data. The delay is measured on an acknowledge for every code, which shows an off-by-one in the counter load or the compare. Seeded random transfers then vary the target address, offsets, lengths, lock state and delay code. The bench checks every byte it reads against its own model of the RAM.

// File: rtl/edid_tgt_pkg.sv
package edid_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_OFFS,
        ST_OACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // Number of cycles from the SCL fall to the SDA update.
    function automatic int unsigned dly_cycles(input int unsigned base, input int unsigned code);
        return base + code;
    endfunction

endpackage

// File: rtl/edid_bus_events.sv
module edid_bus_events
    import edid_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.scl_rise = ~scl_q & scl_i;
        evt.scl_fall = scl_q & ~scl_i;
        evt.start    = scl_q & scl_i & sda_q & ~sda_i;
        evt.stop     = scl_q & scl_i & ~sda_q & sda_i;
    end

    AST_COND_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (evt.start || evt.stop) |-> (scl_i && $past(scl_i))) else $error("bus condition seen with SCL low"); // R1

endmodule

// File: rtl/edid_sda_delay.sv
module edid_sda_delay
    import edid_tgt_pkg::*;
#(
    parameter int unsigned BASE_CYC = 6,
    parameter int unsigned CODE_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_fall,
    input  logic [CODE_W-1:0] code,
    input  logic              drv_req,
    output logic              sda_oe
);

    localparam int unsigned MAX_CYC = BASE_CYC + (1 << CODE_W) - 1;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sda_oe <= 1'b0;
        end else if (scl_fall) begin
            cnt_q <= CNT_W'(dly_cycles(BASE_CYC, 32'(code)));
        end else if (cnt_q == CNT_W'(1)) begin
            cnt_q  <= '0;
            sda_oe <= drv_req;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> ($past(cnt_q) == CNT_W'(1))) else $error("SDA changed outside delay window"); // R8

endmodule

// File: rtl/edid_ram.sv
module edid_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/edid_i2c_target.sv
module edid_i2c_target
    import edid_tgt_pkg::*;
#(
    parameter int unsigned OFS_W    = 8,
    parameter int unsigned BASE_CYC = 6,
    parameter int unsigned CODE_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [6:0]        cfg_dev_addr,
    input  logic              cfg_wr_lock,
    input  logic [CODE_W-1:0] cfg_dly_code,
    output logic              sda_pull
);

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BCNT_W = $clog2(BYTE_W + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);

    bus_evt_t          evt;
    tgt_state_e        st_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [BYTE_W-1:0] sh_q, rd_sh_q, ram_rdata;
    logic [OFS_W-1:0]  ptr_q;
    logic              rw_q, mnack_q, drv_req, ram_we;

    edid_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    edid_ram #(.AW(OFS_W), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ptr_q),
        .wdata (sh_q),
        .raddr (ptr_q),
        .rdata (ram_rdata)
    );

    edid_sda_delay #(.BASE_CYC(BASE_CYC), .CODE_W(CODE_W)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .scl_fall (evt.scl_fall),
        .code     (cfg_dly_code),
        .drv_req  (drv_req),
        .sda_oe   (sda_pull)
    );

    assign ram_we = evt.scl_fall && (st_q == ST_WDATA) && (bcnt_q == LAST_BIT) && !cfg_wr_lock;

    always_comb begin
        unique case (st_q)
            ST_AACK, ST_OACK, ST_WACK: drv_req = 1'b1;
            ST_RDATA:                  drv_req = ~rd_sh_q[BYTE_W-1];
            default:                   drv_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            bcnt_q  <= '0;
            sh_q    <= '0;
            rd_sh_q <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mnack_q <= 1'b0;
        end else if (evt.start) begin
            st_q   <= ST_ADDR;
            bcnt_q <= '0;
        end else if (evt.stop) begin
            st_q <= ST_IDLE;
        end else begin
            if (evt.scl_rise) begin
                unique case (st_q)
                    ST_ADDR, ST_OFFS, ST_WDATA: begin
                        sh_q   <= {sh_q[BYTE_W-2:0], sda_i};
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                    ST_RDATA: bcnt_q  <= bcnt_q + 1'b1;
                    ST_RACK:  mnack_q <= sda_i;
                    default: ;
                endcase
            end
            if (evt.scl_fall) begin
                unique case (st_q)
                    ST_ADDR: if (bcnt_q == LAST_BIT) begin
                        if (sh_q[BYTE_W-1:1] == cfg_dev_addr) begin
                            st_q <= ST_AACK;
                            rw_q <= sh_q[0];
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                    ST_AACK: begin
                        bcnt_q <= '0;
                        if (rw_q) begin
                            st_q    <= ST_RDATA;
                            rd_sh_q <= ram_rdata;
                        end else begin
                            st_q <= ST_OFFS;
                        end
                    end
                    ST_OFFS: if (bcnt_q == LAST_BIT) begin
                        ptr_q <= sh_q[OFS_W-1:0];
                        st_q  <= ST_OACK;
                    end
                    ST_OACK, ST_WACK: begin
                        st_q   <= ST_WDATA;
                        bcnt_q <= '0;
                    end
                    ST_WDATA: if (bcnt_q == LAST_BIT) begin
                        ptr_q <= ptr_q + 1'b1;
                        st_q  <= ST_WACK;
                    end
                    ST_RDATA: begin
                        if (bcnt_q == LAST_BIT) begin
                            st_q  <= ST_RACK;
                            ptr_q <= ptr_q + 1'b1;
                        end else begin
                            rd_sh_q <= {rd_sh_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (mnack_q) begin
                            st_q <= ST_IDLE;
                        end else begin
                            st_q    <= ST_RDATA;
                            rd_sh_q <= ram_rdata;
                            bcnt_q  <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AACK && $past(st_q) == ST_ADDR) |-> ($past(sh_q[BYTE_W-1:1]) == $past(cfg_dev_addr))) else $error("ack without address match"); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WACK && $past(st_q) == ST_WDATA) |-> (ptr_q == OFS_W'($past(ptr_q) + 1'b1))) else $error("pointer did not step"); // R4

    AST_LOCK_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WACK && $past(st_q) == ST_WDATA && $past(cfg_wr_lock)) |-> !$past(ram_we)) else $error("locked RAM written"); // R5

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && $past(st_q) == ST_RACK) |-> !sda_pull) else $error("SDA held after master nack"); // R7

endmodule

// File: tb/edid_i2c_target_tb.sv
module edid_i2c_target_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [6:0] dev = 7'h50;
    logic       lock = 1'b0;
    logic [1:0] dly = 2'd0;
    logic       sda_pull;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    edid_i2c_target u_dut (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .cfg_dev_addr (dev),
        .cfg_wr_lock  (lock),
        .cfg_dly_code (dly),
        .sda_pull     (sda_pull)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mdl [256];
    bit         known [256];
    logic [7:0] mptr = 8'd0;
    logic [7:0] wbuf [16];

    function automatic int exp_delay(input logic [1:0] code);
        return 6 + int'(code);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        return mdl[a];
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        wait_clk(12); sda_m = b;
        wait_clk(8);  scl = 1'b1;
        wait_clk(20); scl = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        wait_clk(12); sda_m = 1'b1;
        wait_clk(8);  scl = 1'b1;
        wait_clk(10); b = sda_bus;
        wait_clk(10); scl = 1'b0;
    endtask

    task automatic do_start;
        if (scl) begin
            wait_clk(10); sda_m = 1'b0;
            wait_clk(10); scl = 1'b0;
        end else begin
            wait_clk(12); sda_m = 1'b1;
            wait_clk(8);  scl = 1'b1;
            wait_clk(10); sda_m = 1'b0;
            wait_clk(10); scl = 1'b0;
        end
    endtask

    task automatic do_stop;
        wait_clk(12); sda_m = 1'b0;
        wait_clk(8);  scl = 1'b1;
        wait_clk(10); sda_m = 1'b1;
        wait_clk(10);
    endtask

    // meas < 0: no delay measurement on the acknowledge
    task automatic write_byte(input logic [7:0] b, output logic ack, input int meas);
        logic bit_v;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        if (meas >= 0) begin
            int n = 0;
            while (!sda_pull && n < 40) begin
                @(negedge clk);
                n++;
            end
            // fall sampled at first edge; update lands meas edges later
            check(n == meas + 1, "R8", "ack delay cycles", n - 1, meas);
        end
        recv_bit(bit_v);
        ack = ~bit_v;
    endtask

    task automatic read_byte(output logic [7:0] b, input logic nack);
        logic bit_v;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(bit_v);
            b[i] = bit_v;
        end
        send_bit(nack);
    endtask

    task automatic wr_xfer(input logic [6:0] a, input logic [7:0] ofs, input int n, input bit meas);
        logic ack;
        bit   hit = (a == dev);
        do_start();
        write_byte({a, 1'b0}, ack, (meas && hit) ? exp_delay(dly) : -1);
        check(ack == hit, "R2", "address ack", int'(ack), int'(hit));
        if (!hit) begin
            do_stop();
            return;
        end
        write_byte(ofs, ack, -1);
        check(ack == 1'b1, "R3", "offset ack", int'(ack), 1);
        mptr = ofs;
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i], ack, -1);
            check(ack == 1'b1, lock ? "R5" : "R4", "data ack", int'(ack), 1);
            if (!lock) begin
                mdl[mptr]   = wbuf[i];
                known[mptr] = 1'b1;
            end
            mptr = mptr + 8'd1;
        end
        do_stop();
    endtask

    task automatic rd_xfer(input logic [7:0] ofs, input bit set_ofs, input int n, input string tag);
        logic       ack;
        logic [7:0] b;
        do_start();
        if (set_ofs) begin
            write_byte({dev, 1'b0}, ack, -1);
            check(ack == 1'b1, "R2", "address ack (write)", int'(ack), 1);
            write_byte(ofs, ack, -1);
            check(ack == 1'b1, "R3", "offset ack", int'(ack), 1);
            mptr = ofs;
            do_start(); // repeated start, R1
        end
        write_byte({dev, 1'b1}, ack, -1);
        check(ack == 1'b1, "R1", "address ack (read)", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            read_byte(b, i == n - 1);
            if (known[mptr])
                check(b == exp_byte(mptr), tag, "read data", int'(b), int'(exp_byte(mptr)));
            mptr = mptr + 8'd1;
        end
        wait_clk(14);
        check(sda_pull == 1'b0, "R7", "SDA released after nack", int'(sda_pull), 0);
        do_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        logic ack;
        int   seed_v;
        seed_v = $urandom(32'd20240611);
        for (int i = 0; i < 256; i++) known[i] = 1'b0;

        wait_clk(8);
        check(sda_pull == 1'b0, "R9", "reset SDA released", int'(sda_pull), 0);
        rst = 1'b0;
        wait_clk(4);
        check(sda_pull == 1'b0, "R9", "idle SDA released", int'(sda_pull), 0);

        // bits without a start: must not be acknowledged
        wait_clk(10); scl = 1'b0;
        write_byte({dev, 1'b0}, ack, -1);
        check(ack == 1'b0, "R9", "no ack without start", int'(ack), 0);
        do_stop();

        // write across the wrap point, with ack delay measured (code 0)
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h44; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        wr_xfer(dev, 8'hFE, 6, 1'b1);

        // offset + repeated start read of FE..01 (R6 wrap), then current-address read
        rd_xfer(8'hFE, 1'b1, 4, "R6");
        check(mptr == 8'h02, "R6", "model pointer", int'(mptr), 2);
        rd_xfer(8'h00, 1'b0, 2, "R6");

        // foreign address: no ack, nothing stored
        wr_xfer(7'h51, 8'h00, 2, 1'b0);
        rd_xfer(8'h00, 1'b1, 2, "R2");

        // locked writes acknowledged but discarded
        lock = 1'b1;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
        wr_xfer(dev, 8'h00, 2, 1'b0);
        lock = 1'b0;
        rd_xfer(8'h00, 1'b1, 2, "R5");

        // remaining delay codes
        for (int c = 1; c < 4; c++) begin
            dly = 2'(c);
            wbuf[0] = 8'(8'h70 + c);
            wr_xfer(dev, 8'(8'h40 + c), 1, 1'b1);
        end

        // seeded random transfers
        for (int it = 0; it < 12; it++) begin
            logic [7:0] ofs;
            int         n;
            dev  = 7'($urandom_range(0, 127));
            dly  = 2'($urandom_range(0, 3));
            lock = ($urandom_range(0, 3) == 0);
            ofs  = 8'($urandom_range(0, 255));
            n    = $urandom_range(1, 5);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom_range(0, 255));
            wr_xfer(dev, ofs, n, 1'b1);
            lock = 1'b0;
            if ($urandom_range(0, 1) == 1)
                rd_xfer(ofs, 1'b1, n, "R6");
            else begin
                mptr = ofs;
                rd_xfer(ofs, 1'b1, 1, "R6");
                rd_xfer(8'h00, 1'b0, n, "R6");
            end
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule